// File: doc/BRIEF.md
# Nested Task Return Link Validator

When an interrupt return is executed while the nested-task flag is set, the processor must go back to the task named by the back-link selector. The back-link selector is stored in the current task-state segment. This block performs that step up to the hand-off to the task-switch engine. A start pulse makes it fetch the 16-bit link word at the base of the current task-state segment and check the selector. If the selector passes, the block fetches the 8-byte descriptor that the selector indexes in the global descriptor table and checks that descriptor in turn.

Each start ends in exactly one outcome:

- a task-switch request carrying the selector and both descriptor dwords;
- a single fault with its vector and error code;
- an internal-error pulse, when the virtual-8086 flag is found set together with the nested-task flag.

A one-cycle done pulse follows the outcome. The two memory fetches use separate request/valid handshakes. The task-switch request uses a request/acknowledge handshake. The switch itself, the descriptor storage and the later instruction-pointer limit check are handled outside the block.

Top module: `nest_link_validator`

## Requirements
- R1: On a start pulse with the virtual-8086 input low, the block raises `wrd_req_o` with `wrd_addr_o` equal to the task-state base sampled at start, and takes the link selector from `wrd_data_i` in the cycle `wrd_valid_i` is high.
- R2: If bit 2 of the link selector (the local-table indicator) is 1, the block raises one fault with vector 10 and error code equal to the selector with bits 1:0 cleared, and issues no descriptor read.
- R3: If the last byte of the indexed entry, `{sel[15:3],3'b111}`, exceeds the global table limit, the block raises a fault with vector 10 and the masked selector as error code, and issues no descriptor read. An entry whose last byte equals the limit passes.
- R4: When the selector passes, the block raises `dsc_req_o` with `dsc_addr_o` = global table base + `sel[15:3]`*8.
- R5: The descriptor is rejected with vector 10 and the masked selector if its segment bit (bit 44) is 1, or if its type field (bits 43:40) is neither 3 nor 11.
- R6: A descriptor that passes R5 but has its present bit (bit 47) clear raises a fault with vector 11 and the masked selector as error code.
- R7: The checks are applied in this order: table indicator, table limit, class and type, present bit. Only the first failing check reports.
- R8: A descriptor that passes every check produces `sw_req_o`. While the request is raised, `sw_sel_o` holds the unmasked selector, `sw_lo_o` holds descriptor bits 31:0 and `sw_hi_o` holds bits 63:32. These stay stable until `sw_ack_i`.
- R9: Each accepted start yields exactly one outcome (fault pulse, acknowledged switch, or internal-error pulse), followed in the next cycle by a one-cycle `done_o`.
- R10: `busy_o` is high from the cycle after an accepted start through the done cycle. A start pulse while busy is ignored and is not queued.
- R11: If the virtual-8086 input is high at start, the block pulses `ierr_o`, issues no memory read, and then signals done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin validation (one-cycle pulse) |
| v86_i | input | 1 | Virtual-8086 flag, sampled at start |
| task_base_i | input | ADDR_W | Current task-state segment base |
| gdt_base_i | input | ADDR_W | Global descriptor table base |
| gdt_limit_i | input | 16 | Global descriptor table limit in bytes |
| wrd_req_o | output | 1 | Link word read request |
| wrd_addr_o | output | ADDR_W | Link word address |
| wrd_valid_i | input | 1 | Link word read data valid |
| wrd_data_i | input | 16 | Link word read data |
| dsc_req_o | output | 1 | Descriptor read request |
| dsc_addr_o | output | ADDR_W | Descriptor address |
| dsc_valid_i | input | 1 | Descriptor read data valid |
| dsc_data_i | input | 64 | Descriptor read data |
| sw_req_o | output | 1 | Task-switch request |
| sw_sel_o | output | 16 | Selector of the target task |
| sw_lo_o | output | 32 | Descriptor low dword |
| sw_hi_o | output | 32 | Descriptor high dword |
| sw_ack_i | input | 1 | Task-switch request accepted |
| fault_o | output | 1 | Fault pulse |
| fault_vec_o | output | 8 | Fault vector (10 or 11) |
| fault_code_o | output | 16 | Fault error code |
| ierr_o | output | 1 | Internal-error pulse |
| busy_o | output | 1 | Validation in progress |
| done_o | output | 1 | Validation finished (one cycle) |

## Verification
The main check chain is driven with the following inputs:

- two good descriptors of the two accepted busy types, one of them with nonzero requested-privilege bits, so the bench can tell the unmasked switch selector from the masked error code;
- a link selector on the local-table side;
- an index whose entry ends exactly at the table limit, and an index one entry further, which separates a correct inclusive bound from an off-by-one;
- a descriptor with the segment bit set, one with an available type, and one that is not present. These show which fault vector each failure selects.

Inputs that fail two checks at once show that the earlier check in the order wins. A virtual-8086 start and a start pulse issued mid-operation confirm that no read is issued, that only one done appears, and that the ignored pulse is not queued.

// File: rtl/nlv_pkg.sv
package nlv_pkg;

    localparam int SEL_W     = 16;
    localparam int DESC_W    = 64;
    localparam int HALF_W    = DESC_W / 2;
    localparam int IDX_LSB   = 3;
    localparam int ATTR_LSB  = 40;
    localparam int ATTR_W    = 8;

    localparam logic [7:0] VEC_BAD_TASK = 8'd10;
    localparam logic [7:0] VEC_ABSENT   = 8'd11;
    localparam logic [3:0] KIND_BUSY16  = 4'd3;
    localparam logic [3:0] KIND_BUSY32  = 4'd11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LINK_RD,
        ST_SEL_CHK,
        ST_DESC_RD,
        ST_DESC_CHK,
        ST_SWITCH,
        ST_FAULT,
        ST_IERR,
        ST_DONE
    } nlv_state_e;

    typedef struct packed {
        logic             fail;
        logic [7:0]       vec;
        logic [SEL_W-1:0] code;
    } nlv_verdict_t;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       seg;
        logic [3:0] kind;
    } nlv_attr_t;

    function automatic logic [SEL_W-1:0] masked_code(input logic [SEL_W-1:0] s);
        return {s[SEL_W-1:2], 2'b00};
    endfunction

    function automatic nlv_attr_t attr_of(input logic [ATTR_W-1:0] b);
        nlv_attr_t a;
        a.present = b[7];
        a.dpl     = b[6:5];
        a.seg     = b[4];
        a.kind    = b[3:0];
        return a;
    endfunction

    function automatic nlv_verdict_t pass_verdict();
        nlv_verdict_t v;
        v.fail = 1'b0;
        v.vec  = '0;
        v.code = '0;
        return v;
    endfunction

endpackage

// File: rtl/nlv_sel_check.sv
module nlv_sel_check
    import nlv_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic [SEL_W-1:0] limit_i,
    output nlv_verdict_t     verdict_o
);
    logic             local_tbl;
    logic             over_limit;
    logic [SEL_W-1:0] last_byte;

    assign local_tbl  = sel_i[2];
    assign last_byte  = {sel_i[SEL_W-1:IDX_LSB], {IDX_LSB{1'b1}}};
    assign over_limit = last_byte > limit_i;

    always_comb begin
        verdict_o = pass_verdict();
        // table indicator takes precedence over the limit test (R7)
        if (local_tbl || over_limit) begin
            verdict_o.fail = 1'b1;
            verdict_o.vec  = VEC_BAD_TASK;
            verdict_o.code = masked_code(sel_i);
        end
    end
endmodule

// File: rtl/nlv_desc_check.sv
module nlv_desc_check
    import nlv_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [ATTR_W-1:0] attr_i,
    output nlv_verdict_t      verdict_o
);
    nlv_attr_t a;
    logic      bad_class;
    logic      bad_kind;

    assign a         = attr_of(attr_i);
    assign bad_class = a.seg;
    assign bad_kind  = (a.kind != KIND_BUSY16) && (a.kind != KIND_BUSY32);

    always_comb begin
        verdict_o = pass_verdict();
        if (bad_class || bad_kind) begin
            verdict_o.fail = 1'b1;
            verdict_o.vec  = VEC_BAD_TASK;
            verdict_o.code = masked_code(sel_i);
        end else if (!a.present) begin
            verdict_o.fail = 1'b1;
            verdict_o.vec  = VEC_ABSENT;
            verdict_o.code = masked_code(sel_i);
        end
    end
endmodule

// File: rtl/nlv_ctrl.sv
module nlv_ctrl
    import nlv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              v86_i,
    input  logic [ADDR_W-1:0] task_base_i,
    input  logic [ADDR_W-1:0] gdt_base_i,
    input  logic [SEL_W-1:0]  gdt_limit_i,
    input  logic              wrd_valid_i,
    input  logic [SEL_W-1:0]  wrd_data_i,
    input  logic              dsc_valid_i,
    input  logic [DESC_W-1:0] dsc_data_i,
    input  logic              sw_ack_i,
    input  nlv_verdict_t      sel_verdict_i,
    input  nlv_verdict_t      desc_verdict_i,
    output nlv_state_e        state_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DESC_W-1:0] desc_o,
    output nlv_verdict_t      fault_o,
    output logic [ADDR_W-1:0] task_base_o,
    output logic [ADDR_W-1:0] gdt_base_o,
    output logic [SEL_W-1:0]  gdt_limit_o
);
    nlv_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            sel_o       <= '0;
            desc_o      <= '0;
            fault_o     <= pass_verdict();
            task_base_o <= '0;
            gdt_base_o  <= '0;
            gdt_limit_o <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        task_base_o <= task_base_i;
                        gdt_base_o  <= gdt_base_i;
                        gdt_limit_o <= gdt_limit_i;
                        fault_o     <= pass_verdict();
                        state       <= v86_i ? ST_IERR : ST_LINK_RD;
                    end
                end
                ST_LINK_RD: begin
                    if (wrd_valid_i) begin
                        sel_o <= wrd_data_i;
                        state <= ST_SEL_CHK;
                    end
                end
                ST_SEL_CHK: begin
                    if (sel_verdict_i.fail) begin
                        fault_o <= sel_verdict_i;
                        state   <= ST_FAULT;
                    end else begin
                        state   <= ST_DESC_RD;
                    end
                end
                ST_DESC_RD: begin
                    if (dsc_valid_i) begin
                        desc_o <= dsc_data_i;
                        state  <= ST_DESC_CHK;
                    end
                end
                ST_DESC_CHK: begin
                    if (desc_verdict_i.fail) begin
                        fault_o <= desc_verdict_i;
                        state   <= ST_FAULT;
                    end else begin
                        state   <= ST_SWITCH;
                    end
                end
                ST_SWITCH: if (sw_ack_i) state <= ST_DONE;
                ST_FAULT:  state <= ST_DONE;
                ST_IERR:   state <= ST_DONE;
                ST_DONE:   state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state;
endmodule

// File: rtl/nest_link_validator.sv
module nest_link_validator
    import nlv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              v86_i,
    input  logic [ADDR_W-1:0] task_base_i,
    input  logic [ADDR_W-1:0] gdt_base_i,
    input  logic [15:0]       gdt_limit_i,
    output logic              wrd_req_o,
    output logic [ADDR_W-1:0] wrd_addr_o,
    input  logic              wrd_valid_i,
    input  logic [15:0]       wrd_data_i,
    output logic              dsc_req_o,
    output logic [ADDR_W-1:0] dsc_addr_o,
    input  logic              dsc_valid_i,
    input  logic [63:0]       dsc_data_i,
    output logic              sw_req_o,
    output logic [15:0]       sw_sel_o,
    output logic [31:0]       sw_lo_o,
    output logic [31:0]       sw_hi_o,
    input  logic              sw_ack_i,
    output logic              fault_o,
    output logic [7:0]        fault_vec_o,
    output logic [15:0]       fault_code_o,
    output logic              ierr_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int PAD_W = ADDR_W - SEL_W;

    nlv_state_e        state;
    logic [SEL_W-1:0]  sel_q;
    logic [DESC_W-1:0] desc_q;
    nlv_verdict_t      fault_q;
    nlv_verdict_t      sel_v;
    nlv_verdict_t      desc_v;
    logic [ADDR_W-1:0] task_base_q;
    logic [ADDR_W-1:0] gdt_base_q;
    logic [SEL_W-1:0]  gdt_limit_q;
    logic [ADDR_W-1:0] entry_off;

    nlv_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .v86_i          (v86_i),
        .task_base_i    (task_base_i),
        .gdt_base_i     (gdt_base_i),
        .gdt_limit_i    (gdt_limit_i),
        .wrd_valid_i    (wrd_valid_i),
        .wrd_data_i     (wrd_data_i),
        .dsc_valid_i    (dsc_valid_i),
        .dsc_data_i     (dsc_data_i),
        .sw_ack_i       (sw_ack_i),
        .sel_verdict_i  (sel_v),
        .desc_verdict_i (desc_v),
        .state_o        (state),
        .sel_o          (sel_q),
        .desc_o         (desc_q),
        .fault_o        (fault_q),
        .task_base_o    (task_base_q),
        .gdt_base_o     (gdt_base_q),
        .gdt_limit_o    (gdt_limit_q)
    );

    nlv_sel_check u_sel (
        .sel_i     (sel_q),
        .limit_i   (gdt_limit_q),
        .verdict_o (sel_v)
    );

    nlv_desc_check u_desc (
        .sel_i     (sel_q),
        .attr_i    (desc_q[ATTR_LSB +: ATTR_W]),
        .verdict_o (desc_v)
    );

    assign entry_off = {{PAD_W{1'b0}}, sel_q[SEL_W-1:IDX_LSB], {IDX_LSB{1'b0}}};

    assign wrd_req_o    = (state == ST_LINK_RD);
    assign wrd_addr_o   = task_base_q;
    assign dsc_req_o    = (state == ST_DESC_RD);
    assign dsc_addr_o   = gdt_base_q + entry_off;
    assign sw_req_o     = (state == ST_SWITCH);
    assign sw_sel_o     = sel_q;
    assign sw_lo_o      = desc_q[HALF_W-1:0];
    assign sw_hi_o      = desc_q[DESC_W-1:HALF_W];
    assign fault_o      = (state == ST_FAULT);
    assign fault_vec_o  = fault_q.vec;
    assign fault_code_o = fault_q.code;
    assign ierr_o       = (state == ST_IERR);
    assign busy_o       = (state != ST_IDLE);
    assign done_o       = (state == ST_DONE);
endmodule

// File: rtl/nlv_checks.sv
module nlv_checks (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        done_o,
    input logic        fault_o,
    input logic [7:0]  fault_vec_o,
    input logic [15:0] fault_code_o,
    input logic        ierr_o,
    input logic        wrd_req_o,
    input logic        dsc_req_o,
    input logic        sw_req_o,
    input logic        sw_ack_i,
    input logic [15:0] sw_sel_o
);
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_o, sw_req_o && sw_ack_i, ierr_o}));

    p_done_follows_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(fault_o || (sw_req_o && sw_ack_i) || ierr_o));

    p_vec_known_r6: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (fault_vec_o == 8'd10 || fault_vec_o == 8'd11));

    p_code_masked_r2: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (fault_code_o[1:0] == 2'b00));

    p_sw_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_req_o && !sw_ack_i) |=> (sw_req_o && $stable(sw_sel_o)));

    p_one_read_r4: assert property (@(posedge clk) disable iff (rst)
        !(wrd_req_o && dsc_req_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(wrd_req_o || dsc_req_o || sw_req_o || fault_o || ierr_o || done_o));
endmodule

bind nest_link_validator nlv_checks u_nlv_checks (
    .clk          (clk),
    .rst          (rst),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .fault_vec_o  (fault_vec_o),
    .fault_code_o (fault_code_o),
    .ierr_o       (ierr_o),
    .wrd_req_o    (wrd_req_o),
    .dsc_req_o    (dsc_req_o),
    .sw_req_o     (sw_req_o),
    .sw_ack_i     (sw_ack_i),
    .sw_sel_o     (sw_sel_o)
);

// File: tb/nest_link_validator_test.sv
`timescale 1ns/1ps
module nest_link_validator_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        v86_i = 1'b0;
    logic [31:0] task_base_i = '0;
    logic [31:0] gdt_base_i = '0;
    logic [15:0] gdt_limit_i = '0;
    logic        wrd_req_o, dsc_req_o, sw_req_o;
    logic [31:0] wrd_addr_o, dsc_addr_o;
    logic        wrd_valid_i = 1'b0;
    logic [15:0] wrd_data_i = '0;
    logic        dsc_valid_i = 1'b0;
    logic [63:0] dsc_data_i = '0;
    logic [15:0] sw_sel_o;
    logic [31:0] sw_lo_o, sw_hi_o;
    logic        sw_ack_i = 1'b0;
    logic        fault_o, ierr_o, busy_o, done_o;
    logic [7:0]  fault_vec_o;
    logic [15:0] fault_code_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // responder memory contents and observations
    logic [15:0] mem_link = '0;
    logic [63:0] mem_desc = '0;
    int n_wrd, n_dsc, n_sw, n_fault, n_ierr, n_done;
    logic [31:0] seen_waddr, seen_daddr;
    logic [15:0] seen_sel, seen_code;
    logic [31:0] seen_lo, seen_hi;
    logic [7:0]  seen_vec;

    always #4 clk = ~clk;

    nest_link_validator uut (
        .clk(clk), .rst(rst), .start_i(start_i), .v86_i(v86_i),
        .task_base_i(task_base_i), .gdt_base_i(gdt_base_i), .gdt_limit_i(gdt_limit_i),
        .wrd_req_o(wrd_req_o), .wrd_addr_o(wrd_addr_o),
        .wrd_valid_i(wrd_valid_i), .wrd_data_i(wrd_data_i),
        .dsc_req_o(dsc_req_o), .dsc_addr_o(dsc_addr_o),
        .dsc_valid_i(dsc_valid_i), .dsc_data_i(dsc_data_i),
        .sw_req_o(sw_req_o), .sw_sel_o(sw_sel_o), .sw_lo_o(sw_lo_o), .sw_hi_o(sw_hi_o),
        .sw_ack_i(sw_ack_i), .fault_o(fault_o), .fault_vec_o(fault_vec_o),
        .fault_code_o(fault_code_o), .ierr_o(ierr_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // responders and monitor, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            wrd_valid_i = 1'b0;
            dsc_valid_i = 1'b0;
            if (sw_ack_i) sw_ack_i = 1'b0;
            else if (sw_req_o) begin
                sw_ack_i = 1'b1;
                n_sw++;
                seen_sel = sw_sel_o; seen_lo = sw_lo_o; seen_hi = sw_hi_o;
            end
            if (wrd_req_o) begin
                wrd_valid_i = 1'b1; wrd_data_i = mem_link;
                n_wrd++; seen_waddr = wrd_addr_o;
            end
            if (dsc_req_o) begin
                dsc_valid_i = 1'b1; dsc_data_i = mem_desc;
                n_dsc++; seen_daddr = dsc_addr_o;
            end
            if (fault_o) begin
                n_fault++; seen_vec = fault_vec_o; seen_code = fault_code_o;
            end
            if (ierr_o) n_ierr++;
            if (done_o) n_done++;
        end
    end

    task automatic clear_obs();
        n_wrd = 0; n_dsc = 0; n_sw = 0; n_fault = 0; n_ierr = 0; n_done = 0;
        seen_waddr = '0; seen_daddr = '0; seen_sel = '0; seen_code = '0;
        seen_lo = '0; seen_hi = '0; seen_vec = '0;
    endtask

    task automatic run_op(input logic v86, input logic [15:0] link, input logic [63:0] desc,
                          input logic [15:0] lim);
        clear_obs();
        mem_link = link; mem_desc = desc;
        task_base_i = 32'h0004_1000; gdt_base_i = 32'h0008_0000; gdt_limit_i = lim;
        v86_i = v86;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R10 busy after start", busy_o === 1'b1, busy_o, 1);
        for (int k = 0; k < 40 && n_done == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 one done", n_done == 1, n_done, 1);
        chk("R10 idle after done", busy_o === 1'b0, busy_o, 0);
    endtask

    task automatic expect_fault(input string tag, input logic [7:0] vec, input logic [15:0] code,
                                input int dreads);
        chk({tag, " fault count"}, n_fault == 1, n_fault, 1);
        chk({tag, " vector"}, seen_vec == vec, seen_vec, vec);
        chk({tag, " code"}, seen_code == code, seen_code, code);
        chk({tag, " desc reads"}, n_dsc == dreads, n_dsc, dreads);
        chk({tag, " R9 no switch"}, n_sw == 0, n_sw, 0);
    endtask

    task automatic t_reset();
        chk("reset busy", busy_o === 1'b0, busy_o, 0);
        chk("reset done", done_o === 1'b0, done_o, 0);
        chk("reset reqs", {wrd_req_o, dsc_req_o, sw_req_o, fault_o, ierr_o} === 5'b0,
            {wrd_req_o, dsc_req_o, sw_req_o, fault_o, ierr_o}, 0);
    endtask

    task automatic t_switch_busy32();
        run_op(1'b0, 16'h0028, 64'h0000_8B00_1234_5678, 16'h00FF);
        chk("R1 word addr", seen_waddr == 32'h0004_1000, seen_waddr, 32'h0004_1000);
        chk("R1 one word read", n_wrd == 1, n_wrd, 1);
        chk("R4 desc addr", seen_daddr == 32'h0008_0028, seen_daddr, 32'h0008_0028);
        chk("R8 switch count", n_sw == 1, n_sw, 1);
        chk("R8 sel", seen_sel == 16'h0028, seen_sel, 16'h0028);
        chk("R8 lo", seen_lo == 32'h1234_5678, seen_lo, 32'h1234_5678);
        chk("R8 hi", seen_hi == 32'h0000_8B00, seen_hi, 32'h0000_8B00);
        chk("R9 no fault", n_fault == 0, n_fault, 0);
    endtask

    task automatic t_switch_busy16();
        run_op(1'b0, 16'h0033, 64'hCAFE_8300_0BAD_F00D, 16'h00FF);
        chk("R5 type 3 accepted", n_sw == 1, n_sw, 1);
        chk("R8 raw sel keeps rpl", seen_sel == 16'h0033, seen_sel, 16'h0033);
        chk("R8 hi", seen_hi == 32'hCAFE_8300, seen_hi, 32'hCAFE_8300);
        chk("R4 desc addr", seen_daddr == 32'h0008_0030, seen_daddr, 32'h0008_0030);
    endtask

    task automatic t_ti_fault();
        run_op(1'b0, 16'h002F, 64'h0000_8B00_0000_0000, 16'h00FF);
        expect_fault("R2 table indicator", 8'd10, 16'h002C, 0);
    endtask

    task automatic t_limit_edge();
        run_op(1'b0, 16'h00F8, 64'h0000_8B00_0000_0001, 16'h00FF);
        chk("R3 last entry at limit passes", n_sw == 1 && n_fault == 0, n_sw, 1);
        run_op(1'b0, 16'h0101, 64'h0000_8B00_0000_0001, 16'h00FF);
        expect_fault("R3 beyond limit", 8'd10, 16'h0100, 0);
    endtask

    task automatic t_class();
        run_op(1'b0, 16'h0010, 64'h0000_9B00_0000_0000, 16'h00FF);
        expect_fault("R5 segment bit", 8'd10, 16'h0010, 1);
    endtask

    task automatic t_type();
        run_op(1'b0, 16'h0012, 64'h0000_8900_0000_0000, 16'h00FF);
        expect_fault("R5 available type", 8'd10, 16'h0010, 1);
    endtask

    task automatic t_absent();
        run_op(1'b0, 16'h0019, 64'h0000_0B00_0000_0000, 16'h00FF);
        expect_fault("R6 not present", 8'd11, 16'h0018, 1);
    endtask

    task automatic t_order();
        run_op(1'b0, 16'h0020, 64'h0000_0900_0000_0000, 16'h00FF);
        expect_fault("R7 type before present", 8'd10, 16'h0020, 1);
        run_op(1'b0, 16'h0106, 64'h0000_8B00_0000_0000, 16'h00FF);
        expect_fault("R7 ti and limit", 8'd10, 16'h0104, 0);
    endtask

    task automatic t_v86();
        run_op(1'b1, 16'h0028, 64'h0000_8B00_0000_0000, 16'h00FF);
        chk("R11 ierr pulse", n_ierr == 1, n_ierr, 1);
        chk("R11 no reads", n_wrd + n_dsc == 0, n_wrd + n_dsc, 0);
        chk("R11 no fault or switch", n_fault + n_sw == 0, n_fault + n_sw, 0);
    endtask

    task automatic t_busy_ignore();
        clear_obs();
        mem_link = 16'h0028; mem_desc = 64'h0000_8B00_0000_0000;
        v86_i = 1'b0; gdt_limit_i = 16'h00FF;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int k = 0; k < 40 && n_done == 0; k++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R10 one word read", n_wrd == 1, n_wrd, 1);
        chk("R10 one done", n_done == 1, n_done, 1);
        chk("R10 not queued", busy_o === 1'b0, busy_o, 0);
    endtask

    initial begin
        for (int k = 0; k < 100000; k++) @(negedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_obs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_switch_busy32();
        t_switch_busy16();
        t_ti_fault();
        t_limit_edge();
        t_class();
        t_type();
        t_absent();
        t_order();
        t_v86();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule